// File: doc/BRIEF.md
# Shared Exclusive Access Monitor

This block keeps the reservation table that decides whether exclusive stores succeed on a memory controller with one port and several masters. It sees one request per cycle on a flat request interface: a valid strobe, a read/write select, an exclusive flag, the requesting master's ID and the byte address. An exclusive load reserves a table slot that holds the address granule and the master ID. An exclusive store is judged against the table. Any store that succeeds clears the reservations on its granule, whichever master owns them.

One table serves every master, so the slots are a shared resource. When an exclusive load needs a slot and none is free, a pseudo-random slot is taken over. The victim index comes from a free-running LFSR, so no master can count on a fixed eviction order. The block has no memory datapath, no channel handshakes and no response routing. It produces one verdict per exclusive store, one cycle after the request.

Top module: `excl_monitor`

## Requirements
- R1: After reset the table is empty: `rsp_valid` is 0 during reset, and the first exclusive store after reset gets a fail (`rsp_ok`=0).
- R2: An exclusive load (`req_write`=0, `req_excl`=1) reserves its granule for its master ID. A later exclusive store from that master to that granule gets okay (`rsp_ok`=1).
- R3: An exclusive store with no entry that matches both its ID and its granule gets fail (`rsp_ok`=0).
- R4: An exclusive store that succeeds clears, in the same cycle, every entry on that granule, whatever their IDs. A later exclusive store to that granule therefore fails.
- R5: A plain store (`req_write`=1, `req_excl`=0) to a reserved granule clears every entry on that granule.
- R6: An exclusive load that repeats an existing ID and granule pair refreshes that entry and takes no second slot.
- R7: Addresses are compared with the low `GRAN_LOG2` bits ignored. Two addresses in the same 2^`GRAN_LOG2`-byte granule match. Addresses in different granules do not.
- R8: The table holds `N_ENTRIES` reservations (16 by default), shared by all masters. That many distinct reservations all survive together.
- R9: An exclusive load that finds all slots full overwrites exactly one existing entry, and the new reservation is kept.
- R10: `rsp_valid` rises exactly one cycle after an exclusive store and at no other time. `rsp_ok` is 0 whenever `rsp_valid` is 0.
- R11: An exclusive store that fails leaves the table unchanged.
- R12: A plain load (`req_write`=0, `req_excl`=0) leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_excl | input | 1 | 1 = exclusive access |
| req_id | input | ID_W | ID of the requesting master |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Verdict for the exclusive store of the previous cycle |
| rsp_ok | output | 1 | 1 = exclusive okay, 0 = exclusive fail |

## Verification
The hardest state to reach from the ports is a full table taking one more reservation. Which slot is lost depends on the LFSR phase, and the bench has no means of predicting it. The stimulus fills every slot with distinct granules and issues one more exclusive load. It then probes each old reservation with an exclusive store and counts the okays: exactly one must be missing, and the newest reservation must survive. Before that, repeated loads to already reserved pairs are mixed into a fill. Every slot then still succeeds, which shows that a refresh takes no slot.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

   localparam int LFSR_MIN_W = 2;
   localparam int LFSR_MAX_W = 6;

   // Second feedback tap of a maximal-length Fibonacci LFSR; the first is the MSB.
   function automatic int lfsr_tap(input int w);
      case (w)
         2:       return 0;
         3:       return 1;
         4:       return 2;
         5:       return 2;
         default: return 4;
      endcase
   endfunction

   typedef enum logic {
      XRSP_FAIL = 1'b0,
      XRSP_OKAY = 1'b1
   } xrsp_e;

endpackage

// File: rtl/excl_lfsr.sv
module excl_lfsr #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   import excl_mon_pkg::*;

   localparam int TAP = lfsr_tap(W);

   generate
      if (W < LFSR_MIN_W || W > LFSR_MAX_W) begin : g_bad_width
         $error("excl_lfsr: width %0d has no tap entry", W);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) state <= W'(1);
      else        state <= {state[W-2:0], state[W-1] ^ state[TAP]};
   end
endmodule

// File: rtl/excl_free_pick.sv
module excl_free_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     busy,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);
   // Lowest-numbered free slot wins.
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/excl_tag_match.sv
module excl_tag_match #(
   parameter int N      = 16,
   parameter int ADDR_W = 32,
   parameter int ID_W   = 4
) (
   input  logic [N-1:0]             valid,
   input  logic [N-1:0][ADDR_W-1:0] keys,
   input  logic [N-1:0][ID_W-1:0]   ids,
   input  logic [ADDR_W-1:0]        req_key,
   input  logic [ID_W-1:0]          req_id,
   output logic [N-1:0]             addr_hit,
   output logic [N-1:0]             own_hit
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_cmp
         assign addr_hit[i] = valid[i] && (keys[i] == req_key);
         assign own_hit[i]  = addr_hit[i] && (ids[i] == req_id);
      end
   endgenerate
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
   parameter int N_ENTRIES = 16,
   parameter int ADDR_W    = 32,
   parameter int ID_W      = 4,
   parameter int GRAN_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_excl,
   input  logic [ID_W-1:0]   req_id,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_ok
);
   import excl_mon_pkg::*;

   localparam int IDX_W  = $clog2(N_ENTRIES);
   localparam int LFSR_W = IDX_W + 1;
   localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LOG2) - ADDR_W'(1));

   generate
      if (N_ENTRIES < 2 || N_ENTRIES > 32 || (1 << IDX_W) != N_ENTRIES) begin : g_bad_depth
         $error("excl_monitor: N_ENTRIES must be a power of two from 2 to 32");
      end
      if (GRAN_LOG2 < 0 || GRAN_LOG2 >= ADDR_W) begin : g_bad_gran
         $error("excl_monitor: GRAN_LOG2 out of range");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("excl_monitor: ID_W must be positive");
      end
   endgenerate

   logic [N_ENTRIES-1:0]             valid_q, valid_d;
   logic [N_ENTRIES-1:0][ADDR_W-1:0] key_q;
   logic [N_ENTRIES-1:0][ID_W-1:0]   id_q;
   logic                             rsp_valid_q;
   xrsp_e                            rsp_code_q;

   logic [ADDR_W-1:0]    req_key;
   logic [N_ENTRIES-1:0] addr_hit, own_hit, clear_mask;
   logic                 any_free;
   logic [IDX_W-1:0]     free_idx, slot;
   logic [LFSR_W-1:0]    lfsr_state;
   logic                 is_xrd, is_xwr, is_pwr, wr_commits, alloc_en, own_any;

   assign req_key = req_addr & GRAN_MASK;

   excl_tag_match #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_match (
      .valid    (valid_q),
      .keys     (key_q),
      .ids      (id_q),
      .req_key  (req_key),
      .req_id   (req_id),
      .addr_hit (addr_hit),
      .own_hit  (own_hit)
   );

   excl_free_pick #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
      .busy     (valid_q),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   excl_lfsr #(.W(LFSR_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr_state)
   );

   always_comb begin
      is_xrd     = req_valid && !req_write && req_excl;
      is_xwr     = req_valid &&  req_write && req_excl;
      is_pwr     = req_valid &&  req_write && !req_excl;
      own_any    = |own_hit;
      wr_commits = is_pwr || (is_xwr && own_any);
      clear_mask = wr_commits ? addr_hit : '0;
      alloc_en   = is_xrd && !own_any;
      slot       = any_free ? free_idx : lfsr_state[IDX_W-1:0];
      valid_d    = valid_q & ~clear_mask;
      if (alloc_en) valid_d[slot] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q     <= '0;
         rsp_valid_q <= 1'b0;
         rsp_code_q  <= XRSP_FAIL;
      end else begin
         valid_q     <= valid_d;
         rsp_valid_q <= is_xwr;
         rsp_code_q  <= (is_xwr && own_any) ? XRSP_OKAY : XRSP_FAIL;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_en) begin
         key_q[slot] <= req_key;
         id_q[slot]  <= req_id;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_ok    = (rsp_code_q == XRSP_OKAY);
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
   parameter int N_ENTRIES = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic                 req_excl,
   input logic                 rsp_valid,
   input logic                 rsp_ok,
   input logic [N_ENTRIES-1:0] entry_valid
);
   AST_XWR_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_excl) |=> rsp_valid);                             // R10
   AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && req_excl) |=> !rsp_valid);                           // R10
   AST_OK_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_ok);                                                         // R10
   AST_EMPTY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_excl && entry_valid == '0) |=> !rsp_ok);          // R3
   AST_XRD_HOLDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_excl) |=> (entry_valid != '0));                  // R2
   AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ((&entry_valid) && req_valid && !req_write) |=> (&entry_valid));                 // R9
   AST_WRITE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> ($countones(entry_valid) <= $past($countones(entry_valid)))); // R4
endmodule

bind excl_monitor excl_monitor_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_excl    (req_excl),
   .rsp_valid   (rsp_valid),
   .rsp_ok      (rsp_ok),
   .entry_valid (valid_q)
);

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 16;
   localparam int AW         = 32;
   localparam int IW         = 4;
   localparam int G          = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_excl = 1'b0;
   logic [IW-1:0] req_id = '0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_ok;

   int checks = 0;
   int bad    = 0;

   typedef struct {int id; logic [AW-1:0] key;} ent_t;
   ent_t tbl[$];
   bit   uncertain = 0;
   bit   last_ok;

   always #(CLK_PERIOD/2) clk = ~clk;

   excl_monitor #(.N_ENTRIES(N), .ADDR_W(AW), .ID_W(IW), .GRAN_LOG2(G)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
   );

   function automatic logic [AW-1:0] gkey(input logic [AW-1:0] a);
      return a & ~((AW'(1) << G) - AW'(1));
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One request, reference update, compare one cycle later.
   task automatic issue(input bit wr, input bit ex, input int id, input logic [AW-1:0] addr,
                        input string req, input bit must_check = 0);
      bit own = 0, exp_v, exp_ok = 0, commits;
      logic [AW-1:0] k = gkey(addr);
      foreach (tbl[i]) if (tbl[i].id == id && tbl[i].key == k) own = 1;
      exp_v = wr && ex;
      if (!wr && ex && !own) begin
         if (tbl.size() >= N) uncertain = 1;
         tbl.push_back('{id, k});
      end
      if (wr) begin
         commits = !ex || own;
         exp_ok  = ex && own;
         if (commits)
            for (int i = tbl.size() - 1; i >= 0; i--) if (tbl[i].key == k) tbl.delete(i);
      end
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_excl = ex;
      req_id = IW'(id); req_addr = addr;
      @(posedge clk); #1;
      chk(req, "rsp_valid", int'(rsp_valid), int'(exp_v));
      if (exp_v && (!uncertain || must_check)) chk(req, "rsp_ok", int'(rsp_ok), int'(exp_ok));
      last_ok = rsp_ok;
   endtask

   task automatic idle(input string req);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #1;
      chk(req, "idle rsp_valid", int'(rsp_valid), 0);
      chk(req, "idle rsp_ok", int'(rsp_ok), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
      @(negedge clk); rst_n = 1'b1;

      // R1: empty table after reset
      issue(1, 1, 1, 32'h100, "R1");
      idle("R10");

      // R2, R7: same granule, different low bits; R4: then freed
      issue(0, 1, 1, 32'h100, "R2");
      issue(1, 1, 1, 32'h10C, "R7");
      issue(1, 1, 1, 32'h100, "R4");

      // R3: wrong master, R7: other granule, R11: failures keep the entry
      issue(0, 1, 1, 32'h200, "R2");
      issue(1, 1, 2, 32'h200, "R3");
      issue(1, 1, 1, 32'h210, "R7");
      issue(1, 1, 1, 32'h200, "R11");

      // R4: one success clears both masters' reservations
      issue(0, 1, 1, 32'h300, "R2");
      issue(0, 1, 2, 32'h304, "R2");
      issue(1, 1, 2, 32'h300, "R4");
      issue(1, 1, 1, 32'h300, "R4");

      // R5: plain store from an unrelated master clears the reservation
      issue(0, 1, 3, 32'h400, "R2");
      issue(1, 0, 5, 32'h40F, "R5");
      issue(1, 1, 3, 32'h400, "R5");

      // R12: plain load has no effect
      issue(0, 1, 3, 32'h500, "R2");
      issue(0, 0, 3, 32'h500, "R12");
      issue(0, 0, 7, 32'h508, "R12");
      issue(1, 1, 3, 32'h500, "R12");
      idle("R10");

      // R6, R8: full fill with refreshing repeats interleaved, all must survive
      for (int i = 0; i < N; i++) begin
         issue(0, 1, i % 4, 32'h1000 + i * 32'h40, "R6");
         if (i > 0) issue(0, 1, (i - 1) % 4, 32'h1000 + (i - 1) * 32'h40 + 4, "R6");
      end
      for (int i = 0; i < N; i++) issue(1, 1, i % 4, 32'h1000 + i * 32'h40, "R8");

      // R9: refill, then one more reservation evicts exactly one old entry
      for (int i = 0; i < N; i++) issue(0, 1, i % 4, 32'h2000 + i * 32'h40, "R8");
      idle("R10");
      issue(0, 1, 9, 32'h9000, "R9");
      issue(1, 1, 9, 32'h9000, "R9", 1);
      begin
         int oks = 0;
         for (int i = 0; i < N; i++) begin
            issue(1, 1, i % 4, 32'h2000 + i * 32'h40, "R9");
            if (last_ok) oks++;
         end
         chk("R9", "surviving old entries", oks, N - 1);
      end
      tbl.delete();
      uncertain = 0;
      issue(1, 1, 0, 32'h2000, "R9");
      idle("R10");

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule